// File: doc/BRIEF.md
# Bus Error Capture Logger

This block sits beside a system bus and watches for completed transfers that come back with an error code. Each errored transfer presents a 10-bit transfer ID, whose upper four bits name the initiator, plus a 4-bit responder ID, a 3-bit error code, a fatal/non-fatal qualifier and the 256-bit data beat. The block keeps one log entry and a multiple-error flag. It raises a correctable interrupt for non-fatal errors and an uncorrectable interrupt for fatal ones. These errors stop no other engine, so the interrupts are the only way they are reported.

When errors pile up, the entry that is kept is the first fatal one. If no error was fatal, it is the latest non-fatal one. Software reads the log through a 64-bit read port. The primary status address clears the log and both interrupts. A debug status address returns the same word with no side effect. Four data addresses return the captured beat, one 64-bit slice each.

Top module: `bus_err_logger`

## Requirements
- R1: After reset both interrupts are low, the status word reads 64'h0000_0000_8000_0000 and every data word reads zero.
- R2: The status word holds the transfer ID in bits 17:8, the responder ID in bits 21:18, the error code in bits 24:22 and the multiple-error flag in bit 30. Bit 31 always reads 1. Bits 7:0, 29:25 and 63:32 read 0.
- R3: A non-fatal error sets irq_corr and a fatal error sets irq_uncorr, in the cycle after the error is presented. Each stays set until a clearing read.
- R4: An error that arrives while an entry is already logged sets the multiple-error flag.
- R5: Once a fatal error is logged, later errors never change the logged fields or data until the log is cleared.
- R6: While the logged entry is non-fatal, a new error of either kind replaces the entry.
- R7: A read of address 8'h00 returns the contents as they stood before the read. It then clears the log, the flag, the data and both interrupts.
- R8: A read of address 8'h08 returns the same word as address 8'h00 and changes no state.
- R9: Addresses 8'h20, 8'h28, 8'h30 and 8'h38 return the captured data bits 255:192, 191:128, 127:64 and 63:0, in that order.
- R10: An error presented in the same cycle as a clearing read is logged after the clear, with the multiple-error flag at 0.
- R11: Read data appears in the cycle after rd_en. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | An errored transfer completes this cycle |
| err_fatal | input | 1 | Error is fatal (uncorrectable) |
| err_tid | input | 10 | Transfer ID; top 4 bits name the initiator |
| err_rid | input | 4 | Responder ID |
| err_code | input | 3 | Error code |
| err_data | input | 256 | Data beat of the errored transfer |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 64 | Read data, one cycle after rd_en |
| irq_corr | output | 1 | Correctable (non-fatal) error interrupt |
| irq_uncorr | output | 1 | Uncorrectable (fatal) error interrupt |

## Verification
An error presented before a clock edge is visible on the interrupts, and to any later read, just after that edge. Read data taken at an edge reflects the state before that edge's update. The bench therefore drives one cycle of stimulus and computes the expected read word from its model before it applies the cycle's update. It then samples one time unit after the edge and compares both the read data and the interrupts. Same-cycle clear and error, held fatal entries and unmapped addresses are forced by directed steps. Random steps mix everything else.

// File: rtl/bel_pkg.sv
package bel_pkg;
  parameter int TID_W  = 10;
  parameter int RID_W  = 4;
  parameter int CODE_W = 3;
  parameter int WORD_W = 64;

  localparam logic [7:0] A_STATUS = 8'h00;
  localparam logic [7:0] A_DEBUG  = 8'h08;

  typedef struct packed {
    logic              valid;
    logic              fatal;
    logic              mult;
    logic [TID_W-1:0]  tid;
    logic [RID_W-1:0]  rid;
    logic [CODE_W-1:0] code;
  } log_t;

  // status word layout: 31 one, 30 mult, 24:22 code, 21:18 rid, 17:8 tid
  function automatic logic [WORD_W-1:0] pack_status(input log_t l);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[17:8]  = l.tid;
    w[21:18] = l.rid;
    w[24:22] = l.code;
    w[30]    = l.mult;
    w[31]    = 1'b1;
    return w;
  endfunction

  // overwrite policy: empty log or non-fatal entry gives way
  function automatic logic may_replace(input logic have, input logic have_fatal);
    return !have || !have_fatal;
  endfunction
endpackage

// File: rtl/bel_capture.sv
module bel_capture
  import bel_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_valid,
  input  logic                 err_fatal,
  input  logic [TID_W-1:0]     err_tid,
  input  logic [RID_W-1:0]     err_rid,
  input  logic [CODE_W-1:0]    err_code,
  input  logic [DATA_W-1:0]    err_data,
  input  logic                 clr_req,
  output log_t                 log_q,
  output logic [DATA_W-1:0]    data_q,
  output logic                 irq_corr,
  output logic                 irq_uncorr,
  output logic                 take_new
);
  log_t              base, log_d;
  logic [DATA_W-1:0] data_d;
  logic              corr_d, unc_d;

  always_comb begin
    base     = clr_req ? '0 : log_q;
    data_d   = clr_req ? '0 : data_q;
    take_new = err_valid && may_replace(base.valid, base.fatal);
    log_d    = base;
    if (err_valid && base.valid) log_d.mult = 1'b1;
    if (take_new) begin
      log_d.valid = 1'b1;
      log_d.fatal = err_fatal;
      log_d.tid   = err_tid;
      log_d.rid   = err_rid;
      log_d.code  = err_code;
      data_d      = err_data;
    end
    corr_d = (irq_corr   && !clr_req) || (err_valid && !err_fatal);
    unc_d  = (irq_uncorr && !clr_req) || (err_valid &&  err_fatal);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_q      <= '0;
      data_q     <= '0;
      irq_corr   <= 1'b0;
      irq_uncorr <= 1'b0;
    end else begin
      log_q      <= log_d;
      data_q     <= data_d;
      irq_corr   <= corr_d;
      irq_uncorr <= unc_d;
    end
  end

  p_fatal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q.valid && log_q.fatal && !clr_req) |=>
      ($stable(log_q.tid) && $stable(log_q.rid) && $stable(log_q.code) && $stable(data_q)));
  p_mult_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q.valid && err_valid && !clr_req) |=> log_q.mult);
  p_uncorr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_fatal) |=> irq_uncorr);
  p_corr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_fatal) |=> irq_corr);
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !err_valid) |=> (!irq_corr && !irq_uncorr && !log_q.valid && !log_q.mult));
  p_clear_keep_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && err_valid) |=> (log_q.valid && !log_q.mult));
endmodule

// File: rtl/bel_readmux.sv
module bel_readmux
  import bel_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] status_w,
  input  logic [DATA_W-1:0] data_q,
  output logic              clr_req,
  output logic [WORD_W-1:0] rd_data
);
  localparam int NWORDS = DATA_W / WORD_W;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int DBASE  = NWORDS * 8;

  logic [WORD_W-1:0] words [NWORDS];
  logic              hit_stat, hit_dbg, hit_data;
  logic [IDX_W-1:0]  widx;
  logic [WORD_W-1:0] sel_w;
  logic              stat_q, miss_q;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    assign words[gi] = data_q[DATA_W-1-gi*WORD_W -: WORD_W];
  end

  always_comb begin
    hit_stat = (rd_addr == ADDR_W'(A_STATUS));
    hit_dbg  = (rd_addr == ADDR_W'(A_DEBUG));
    hit_data = (int'(rd_addr) >= DBASE) && (int'(rd_addr) < 2*DBASE) && (rd_addr[2:0] == 3'b000);
    widx     = rd_addr[IDX_W+2:3];
    clr_req  = rd_en && hit_stat;
    if (hit_stat || hit_dbg) sel_w = status_w;
    else if (hit_data)       sel_w = words[widx];
    else                     sel_w = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      stat_q  <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      stat_q <= rd_en && (hit_stat || hit_dbg);
      miss_q <= rd_en && !(hit_stat || hit_dbg || hit_data);
      if (rd_en) rd_data <= sel_w;
    end
  end

  p_status_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |-> (rd_data[31] && rd_data[7:0] == 8'h00 && rd_data[29:25] == 5'h00 && rd_data[63:32] == '0));
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> (rd_data == '0));
endmodule

// File: rtl/bus_err_logger.sv
module bus_err_logger
  import bel_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic              err_fatal,
  input  logic [9:0]        err_tid,
  input  logic [3:0]        err_rid,
  input  logic [2:0]        err_code,
  input  logic [DATA_W-1:0] err_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data,
  output logic              irq_corr,
  output logic              irq_uncorr
);
  log_t              log_q;
  logic [DATA_W-1:0] data_q;
  logic              clr_req;
  logic              take_new;
  logic [63:0]       status_w;

  assign status_w = pack_status(log_q);

  bel_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_fatal(err_fatal),
    .err_tid(err_tid), .err_rid(err_rid), .err_code(err_code), .err_data(err_data),
    .clr_req(clr_req), .log_q(log_q), .data_q(data_q),
    .irq_corr(irq_corr), .irq_uncorr(irq_uncorr), .take_new(take_new)
  );

  bel_readmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .status_w(status_w), .data_q(data_q), .clr_req(clr_req), .rd_data(rd_data)
  );

  p_quiet_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !err_valid) |=> ($stable(status_w) && $stable(data_q)));
  p_replace_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_new && !err_fatal) |=> (log_q.valid && !log_q.fatal));
endmodule

// File: tb/sim_bus_err_logger.sv
module sim_bus_err_logger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0, err_fatal = 1'b0;
  logic [9:0] err_tid = '0;
  logic [3:0] err_rid = '0;
  logic [2:0] err_code = '0;
  logic [255:0] err_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic irq_corr, irq_uncorr;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  bus_err_logger u0 (.*);

  // bench model
  bit m_valid, m_fatal, m_mult, m_corr, m_unc;
  logic [9:0] m_tid; logic [3:0] m_rid; logic [2:0] m_code; logic [255:0] m_data;

  function automatic logic [63:0] exp_read(input logic [7:0] a);
    logic [63:0] w = '0;
    if (a == 8'h00 || a == 8'h08) begin
      w[31] = 1'b1; w[30] = m_mult; w[24:22] = m_code; w[21:18] = m_rid; w[17:8] = m_tid;
    end else if (a[7:5] == 3'b001 && a[2:0] == 3'b000) begin
      w = m_data[255 - 64*int'(a[4:3]) -: 64];
    end
    return w;
  endfunction

  function automatic void model_step(input bit ev, input bit ef, input logic [9:0] t,
      input logic [3:0] r, input logic [2:0] c, input logic [255:0] d, input bit re, input logic [7:0] a);
    bit take;
    if (re && a == 8'h00) begin
      m_valid = 0; m_fatal = 0; m_mult = 0; m_corr = 0; m_unc = 0;
      m_tid = '0; m_rid = '0; m_code = '0; m_data = '0;
    end
    if (ev) begin
      take = !m_valid || !m_fatal;
      if (m_valid) m_mult = 1;
      if (take) begin
        m_valid = 1; m_fatal = ef; m_tid = t; m_rid = r; m_code = c; m_data = d;
      end
      if (ef) m_unc = 1; else m_corr = 1;
    end
  endfunction

  function automatic void check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic logic [255:0] rnd_data();
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[32*i +: 32] = $urandom;
    return d;
  endfunction

  task automatic cyc(input bit ev, input bit ef, input logic [9:0] t, input logic [3:0] r,
      input logic [2:0] c, input logic [255:0] d, input bit re, input logic [7:0] a, input string tag);
    logic [63:0] e;
    err_valid = ev; err_fatal = ef; err_tid = t; err_rid = r; err_code = c; err_data = d;
    rd_en = re; rd_addr = a;
    e = exp_read(a);
    model_step(ev, ef, t, r, c, d, re, a);
    @(posedge clk); #1;
    err_valid = 0; rd_en = 0;
    if (re) check({tag, " read"}, rd_data, e);
    check({tag, " irq_corr R3"}, {63'b0, irq_corr}, {63'b0, m_corr});
    check({tag, " irq_uncorr R3"}, {63'b0, irq_uncorr}, {63'b0, m_unc});
  endtask

  task automatic err(input bit ef, input string tag);
    cyc(1, ef, 10'($urandom), 4'($urandom), 3'($urandom), rnd_data(), 0, 8'h00, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(0, 0, '0, '0, '0, '0, 1, a, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_valid = 0; m_fatal = 0; m_mult = 0; m_corr = 0; m_unc = 0;
    m_tid = '0; m_rid = '0; m_code = '0; m_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 irq_corr", {63'b0, irq_corr}, 64'h0);
    check("R1 irq_uncorr", {63'b0, irq_uncorr}, 64'h0);
    rd(8'h08, "R1 debug status");
    check("R1 status value", rd_data, 64'h0000_0000_8000_0000);
    rd(8'h20, "R1 data0");
    rd(8'h38, "R1 data3");
    // R2/R3 first non-fatal error
    err(0, "R3 nonfatal");
    rd(8'h08, "R2 field layout");
    rd(8'h08, "R8 debug repeat no side effect");
    // R4/R6 second non-fatal replaces
    err(0, "R6 second nonfatal");
    rd(8'h08, "R4 mult and R6 replace");
    // R6 fatal replaces non-fatal; R5 holds
    err(1, "R6 fatal replaces");
    err(1, "R5 later fatal");
    err(0, "R5 later nonfatal");
    rd(8'h08, "R5 fatal held");
    for (int i = 0; i < 4; i++) rd(8'h20 + 8'(i*8), "R9 data word");
    // R7 clearing read
    rd(8'h00, "R7 clearing read");
    rd(8'h00, "R7 after clear");
    rd(8'h28, "R7 data cleared");
    // R10 clear plus error in one cycle
    err(0, "R10 prime");
    err(1, "R10 prime2");
    cyc(1, 0, 10'h2A5, 4'h9, 3'h6, rnd_data(), 1, 8'h00, "R10 clear with error");
    rd(8'h08, "R10 logged after clear");
    rd(8'h30, "R10 data kept");
    // R11 unmapped
    rd(8'h10, "R11 unmapped 10");
    rd(8'h21, "R11 misaligned");
    rd(8'h40, "R11 past data");
    rd(8'hF8, "R11 high");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit ev = ($urandom % 4) == 0;
      bit ef = ($urandom % 3) == 0;
      bit re = ($urandom % 3) == 0;
      logic [7:0] a;
      case ($urandom % 8)
        0: a = 8'h00;
        1, 2: a = 8'h08;
        3, 4: a = 8'h20 + 8'(($urandom % 4) * 8);
        default: a = 8'($urandom);
      endcase
      cyc(ev, ef, 10'($urandom), 4'($urandom), 3'($urandom), rnd_data(), re, a, "R4 R5 R6 R7 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule